// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes a small set of interrupt request pins from devices outside the chip and turns them into a prioritised request for the processor core. Each pin is brought into the system clock domain through a synchronizer. A stability filter then rejects any change that does not persist for two consecutive clock samples. A per-pin polarity bit selects whether the rising or the falling transition of the filtered signal counts as a request.

An accepted request sets a pending flag for that pin. The flag stays set until software clears it with a write-one-to-clear strobe. Each pin carries a 3-bit priority level, and level 0 disables the pin. The block reports the highest level among the pending, enabled pins.

When the core acknowledges a level, the block returns a vector number it generates itself. The vector is a programmable base plus the number of the winning pin. When no pin matches the acknowledged level, the vector is the base alone, which serves as a spurious-interrupt vector.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `pend_o`, `irq_level_o` and `iack_valid_o` are all zero.
- R2: A pin change that is sampled on fewer than two consecutive rising clock edges is ignored. A change held for two or more samples is accepted. If the new value is first sampled at edge E0, the pending bit is visible after edge E4.
- R3: Bit k of `cfg_pol_i` selects the active edge of pin k+1: 1 means the rising edge and 0 means the falling edge. The opposite transition never sets pending, and neither does a pin that sits at its inactive level from reset.
- R4: Once set, pending bit k of `pend_o` stays set after the pin returns to its inactive level, until it is cleared.
- R5: When `clr_we_i` is high, each 1 in `clr_mask_i` clears the matching pending bit at the next edge. Bits written as 0 leave their pending bits unchanged.
- R6: When an accepted active edge and a clear of the same pin fall in the same cycle, the pin stays pending.
- R7: Bits [3k+2:3k] of `cfg_prio_i` give the priority of pin k+1. A pin with priority 0 can still become pending, but it takes no part in `irq_level_o` or in acknowledge matching.
- R8: `irq_level_o` equals the maximum priority among the pending, enabled pins, one clock after `pend_o` changes. It is 0 when no such pin exists.
- R9: A cycle with `iack_i` high and level L produces `iack_valid_o` high in the next cycle. In that cycle `iack_vec_o` equals `cfg_vbase_i` + n, where n (1-based) is the highest-numbered pending, enabled pin whose priority equals L. If no pin matches, `iack_vec_o` equals `cfg_vbase_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | NUM_PINS | Raw external request pins; bit k is pin k+1 |
| cfg_pol_i | input | NUM_PINS | Active edge per pin, 1 = rising, 0 = falling |
| cfg_prio_i | input | NUM_PINS*PRIO_W | Packed per-pin priority levels, 0 = disabled |
| cfg_vbase_i | input | VEC_W | Vector base number |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | NUM_PINS | Write-one-to-clear mask for pending bits |
| iack_i | input | 1 | Interrupt acknowledge request |
| iack_level_i | input | PRIO_W | Level being acknowledged |
| pend_o | output | NUM_PINS | Pending flags |
| irq_level_o | output | PRIO_W | Highest pending enabled priority level |
| iack_vec_o | output | VEC_W | Vector number returned on acknowledge |
| iack_valid_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
A wrong filter or synchronizer state appears as a pending bit that is set one edge early, one edge late, or by a single-sample glitch. The bench checks the cycle exactly, one edge before and one edge after pending is expected to appear. A corrupted pending flag shows up on `pend_o` at once, and on `irq_level_o` one clock later. A fault in the arbiter shows up in the vector of the very next acknowledge. The acknowledge tests cover tied levels, a disabled pin and a level with no match, so each of those paths reaches the vector port.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/irq_pin_filter.sv
module irq_pin_filter
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic pend_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic samp;
  logic hist_q, filt_q, filt_d_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // value is adopted only when two consecutive samples agree
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= 1'b0;
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
    end else begin
      hist_q   <= samp;
      filt_d_q <= filt_q;
      if (samp == hist_q) filt_q <= samp;
    end
  end

  assign edge_o = (edge_pol_e'(pol_i) == POL_RISE) ? (filt_q & ~filt_d_q)
                                                   : (~filt_q & filt_d_q);

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (edge_o) pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R2: a filtered change is backed by two equal samples
  a_r2_two_samples: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(samp, 1) == filt_q) && ($past(samp, 2) == filt_q));
  // R6: an edge always leaves the pin pending
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> pend_o);
  // R4: pending holds without a clear
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clr_i) |=> pend_o);
  // R5: a clear without an edge empties the latch
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !edge_o) |=> !pend_o);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_PINS = 6,
  parameter int PRIO_W   = 3,
  localparam int IDX_W   = $clog2(NUM_PINS + 1)
) (
  input  logic [NUM_PINS-1:0]        pend_i,
  input  logic [NUM_PINS*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]          ack_level_i,
  output logic [PRIO_W-1:0]          max_level_o,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           hit_idx_o
);
  always_comb begin
    max_level_o = '0;
    hit_o       = 1'b0;
    hit_idx_o   = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pend_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0)) begin
        if (prio_i[i*PRIO_W +: PRIO_W] > max_level_o)
          max_level_o = prio_i[i*PRIO_W +: PRIO_W];
        // ascending scan: the later, higher-numbered pin wins ties
        if (prio_i[i*PRIO_W +: PRIO_W] == ack_level_i) begin
          hit_o     = 1'b1;
          hit_idx_o = IDX_W'(i + 1);
        end
      end
    end
  end

  // R7: a disabled level never produces a match
  always_comb begin
    if (hit_o) a_r7_no_zero_hit: assert (ack_level_i != '0);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_PINS    = 6,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        irq_pin_i,
  input  logic [NUM_PINS-1:0]        cfg_pol_i,
  input  logic [NUM_PINS*PRIO_W-1:0] cfg_prio_i,
  input  logic [VEC_W-1:0]           cfg_vbase_i,
  input  logic                       clr_we_i,
  input  logic [NUM_PINS-1:0]        clr_mask_i,
  input  logic                       iack_i,
  input  logic [PRIO_W-1:0]          iack_level_i,
  output logic [NUM_PINS-1:0]        pend_o,
  output logic [PRIO_W-1:0]          irq_level_o,
  output logic [VEC_W-1:0]           iack_vec_o,
  output logic                       iack_valid_o
);
  localparam int IDX_W = $clog2(NUM_PINS + 1);

  logic [NUM_PINS-1:0] pend_w, edge_w;
  logic [PRIO_W-1:0]   max_level;
  logic                hit;
  logic [IDX_W-1:0]    hit_idx;
  logic [PRIO_W-1:0]   lvl_q;
  logic [VEC_W-1:0]    vec_q;
  logic                valid_q;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    irq_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (irq_pin_i[k]),
      .pol_i  (cfg_pol_i[k]),
      .clr_i  (clr_we_i & clr_mask_i[k]),
      .pend_o (pend_w[k]),
      .edge_o (edge_w[k])
    );
  end

  irq_prio_arb #(.NUM_PINS(NUM_PINS), .PRIO_W(PRIO_W)) u_arb (
    .pend_i      (pend_w),
    .prio_i      (cfg_prio_i),
    .ack_level_i (iack_level_i),
    .max_level_o (max_level),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      lvl_q   <= max_level;
      valid_q <= iack_i;
      if (iack_i) vec_q <= cfg_vbase_i + (hit ? VEC_W'(hit_idx) : '0);
    end
  end

  assign pend_o       = pend_w;
  assign irq_level_o  = lvl_q;
  assign iack_vec_o   = vec_q;
  assign iack_valid_o = valid_q;

  // R8: no pending pin means level 0 on the next clock
  a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
    (pend_o == '0) |=> (irq_level_o == '0));
  // R9: each acknowledge is answered in the next cycle
  a_r9_ack_answer: assert property (@(posedge clk) disable iff (rst)
    iack_i |=> iack_valid_o);
  a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !iack_i |=> !iack_valid_o);
  // R1: released from reset with all outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (pend_o == '0) && (irq_level_o == '0) && !iack_valid_o);
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  pins = 6'b110000;
  logic [5:0]  pol = 6'b001111;
  logic [17:0] prio = {3'd3, 3'd1, 3'd0, 3'd5, 3'd5, 3'd2};
  logic [7:0]  vbase = 8'h40;
  logic        clr_we = 1'b0;
  logic [5:0]  clr_mask = '0;
  logic        iack = 1'b0;
  logic [2:0]  iack_lvl = '0;
  logic [5:0]  pend;
  logic [2:0]  lvl;
  logic [7:0]  vec;
  logic        vld;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_pin_i(pins), .cfg_pol_i(pol), .cfg_prio_i(prio),
    .cfg_vbase_i(vbase), .clr_we_i(clr_we), .clr_mask_i(clr_mask), .iack_i(iack),
    .iack_level_i(iack_lvl), .pend_o(pend), .irq_level_o(lvl), .iack_vec_o(vec),
    .iack_valid_o(vld)
  );

  typedef struct {
    string      tag;
    bit         is_ack;
    logic [5:0] pend;
    logic [2:0] lvl;
    logic [7:0] vec;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (e.is_ack) begin
        if (!vld || vec !== e.vec) begin
          fails++;
          $display("FAIL %s: valid=%0b vec=%h expected valid=1 vec=%h", e.tag, vld, vec, e.vec);
        end
      end else if (pend !== e.pend || lvl !== e.lvl) begin
        fails++;
        $display("FAIL %s: pend=%b lvl=%0d expected pend=%b lvl=%0d", e.tag, pend, lvl, e.pend, e.lvl);
      end
    end
  end

  task automatic expect_state(string tag, logic [5:0] p, logic [2:0] l);
    @(posedge clk); #1;
    q.push_back('{tag, 1'b0, p, l, 8'h00});
    @(negedge clk); #1;
  endtask

  task automatic expect_ack(string tag, logic [2:0] l, logic [7:0] v);
    @(negedge clk); iack = 1'b1; iack_lvl = l;
    @(posedge clk); #1;
    q.push_back('{tag, 1'b1, 6'b0, 3'd0, v});
    @(negedge clk); iack = 1'b0; #1;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
  endtask

  task automatic hold_pin(int idx, logic v, int n);
    @(negedge clk); pins[idx] = v;
    repeat (n) @(negedge clk);
    pins[idx] = ~v;
  endtask

  task automatic clear(logic [5:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    expect_state("R1 reset state", 6'b000000, 3'd0);
    settle();
    expect_state("R3 idle-high falling pins", 6'b000000, 3'd0);

    hold_pin(0, 1'b1, 1);
    settle();
    expect_state("R2 single-sample glitch", 6'b000000, 3'd0);

    // exact latency: first sample at E0, pending after E4, level after E5
    @(negedge clk) pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    expect_state("R2 not yet at E3", 6'b000000, 3'd0);
    expect_state("R2 pending at E4", 6'b000001, 3'd0);
    expect_state("R8 level one clock later", 6'b000001, 3'd2);
    pins[0] = 1'b0;
    settle();
    expect_state("R4 held after pin release", 6'b000001, 3'd2);

    hold_pin(4, 1'b0, 3);
    settle();
    expect_state("R3 falling pin5, return rise ignored", 6'b010001, 3'd2);
    clear(6'b010000);
    settle();
    expect_state("R5 clear pin5", 6'b000001, 3'd2);

    hold_pin(3, 1'b1, 2);
    settle();
    expect_state("R7 disabled pin4 pends, no level", 6'b001001, 3'd2);

    hold_pin(1, 1'b1, 2);
    settle();
    expect_state("R8 max level", 6'b001011, 3'd5);
    expect_ack("R9 ack level5 pin2", 3'd5, 8'h42);

    hold_pin(2, 1'b1, 2);
    settle();
    expect_state("R8 tie level", 6'b001111, 3'd5);
    expect_ack("R9 tie goes to pin3", 3'd5, 8'h43);
    expect_ack("R9 ack level2 pin1", 3'd2, 8'h41);
    expect_ack("R7 level0 ack spurious", 3'd0, 8'h40);
    expect_ack("R9 no match spurious", 3'd4, 8'h40);

    clear(6'b000100);
    settle();
    expect_state("R5 clear pin3", 6'b001011, 3'd5);
    clear(6'b000000);
    settle();
    expect_state("R5 zero mask no effect", 6'b001011, 3'd5);

    // edge and clear of pin1 in the same cycle
    @(negedge clk) pins[0] = 1'b1;
    repeat (4) @(negedge clk);
    clr_we = 1'b1; clr_mask = 6'b000001;
    @(negedge clk) clr_we = 1'b0; clr_mask = '0;
    settle();
    expect_state("R6 edge beats clear", 6'b001011, 3'd5);
    pins[0] = 1'b0;
    settle();
    clear(6'b000001);
    settle();
    expect_state("R5 later clear works", 6'b001010, 3'd5);

    clear(6'b000010);
    settle();
    expect_state("R7 only disabled pending", 6'b001000, 3'd0);
    clear(6'b111111);
    settle();
    expect_state("R8 all clear level 0", 6'b000000, 3'd0);

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule